// File: doc/BRIEF.md
# PSRAM Power and Deep-Sleep Sequencer

This block owns the sleep pin (`zz_n`, active low) of a pseudo-static RAM and every power-related sequence around it. A separate access controller runs ordinary reads and writes. This block tells that controller when it may use the bus through `acc_grant`. After reset it withholds the grant until the power-up settling time has passed. A host then sends one of three commands:

- program the 5-bit memory-mode configuration;
- put the device to sleep;
- wake it.

Programming the configuration follows a fixed order. The grant is withdrawn and the block waits for the access controller to report the bus idle. It then pulls `zz_n` low and waits out the setup interval. Only then does it ask the access controller for a write cycle, whose low address bits carry the configuration code. Sleep follows a similar order. After the bus drains, `zz_n` stays low for at least the minimum dwell time. A wake command that arrives earlier is held back until the dwell has elapsed. If the stored configuration selects true deep sleep (bit 4 equal to 0), a recovery interval follows the wake, and a sticky flag records that memory contents may be lost. Otherwise the device was only in partial-array standby, and the grant returns at once.

Commands use a valid/ready handshake. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high in two cases only: when the block is idle with the grant given, and when the device sleeps with no wake yet pending. At all other times the host must hold the command and wait. The only condition on the access controller side is that `cfg_wr_req` stays asserted until the controller answers with `cfg_wr_done`.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted the outputs are: `zz_n`=1, `acc_grant`=0, `cmd_ready`=0, `cfg_wr_req`=0, `st_sleep`=0, `st_recover`=0, `st_mem_lost`=0 and `st_cfg`=5'b10000.
- R2: After reset is released, `acc_grant` and `cmd_ready` stay low for at least PWRUP_CYC clock cycles. `acc_grant` then rises within two further cycles.
- R3: Command encoding on `cmd_op` is 0 = no-op, 1 = program configuration, 2 = enter sleep, 3 = wake. `cmd_ready` is high only while `acc_grant` is high, or while `st_sleep` is high and no wake has been accepted.
- R4: After a program or sleep command is accepted, `acc_grant` drops at once. `zz_n` does not fall until `acc_idle` has been seen high on the previous edge.
- R5: For a program command, `zz_n` is low for at least CFG_SETUP_CYC cycles before `cfg_wr_req` rises. `cfg_wr_addr` equals the accepted code and stays stable while the request is high. The request holds until `cfg_wr_done` arrives. After that, `zz_n` returns high, the grant comes back and `st_cfg` shows the new code.
- R6: For a sleep command, `zz_n` stays low and `st_sleep` stays high for at least MIN_SLEEP_CYC cycles. The grant stays low throughout.
- R7: A wake command accepted before the minimum dwell has elapsed is held. `zz_n` stays low until the dwell is met, and only then rises.
- R8: When `st_cfg` bit 4 is 0 (deep sleep), waking is followed by at least RECOVER_CYC cycles with `st_recover` high and `acc_grant` low. When bit 4 is 1 (partial-array standby), `acc_grant` rises on the same edge that `zz_n` rises, and `st_recover` never goes high.
- R9: `st_mem_lost` rises when the block leaves a deep sleep and stays high until reset. Leaving partial-array standby does not set it.
- R10: `acc_grant` is never high while `zz_n` is low or `cfg_wr_req` is high.
- R11: A command that does not fit the current state is consumed and has no effect. This covers a wake or no-op while idle, and a program or enter-sleep command while asleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | Command code (0 no-op, 1 program, 2 sleep, 3 wake) |
| cmd_cfg | input | CFG_W | Configuration code for a program command |
| acc_idle | input | 1 | Access controller has the chip deselected |
| cfg_wr_req | output | 1 | Request for the configuration write cycle |
| cfg_wr_addr | output | CFG_W | Low address bits for the configuration write |
| cfg_wr_done | input | 1 | Access controller finished the configuration write |
| zz_n | output | 1 | Sleep/configuration pin to the memory, active low |
| acc_grant | output | 1 | Access controller may run ordinary accesses |
| st_sleep | output | 1 | Device is held in sleep |
| st_recover | output | 1 | Post-deep-sleep recovery in progress |
| st_mem_lost | output | 1 | A deep sleep has occurred since reset |
| st_cfg | output | CFG_W | Configuration code last written |

## Verification
Most wrong states show up on the grant pin within one cycle, either as a grant issued while `zz_n` is low or as a missing grant after a sequence should have ended. A timer loaded with the wrong interval shows up only in the measured length of a low-`zz_n` or recovery window. The bench therefore measures those lengths in cycles and compares them with the parameters. A misread deep-sleep bit has a different effect. It either inserts or skips a whole recovery window, and it changes `st_mem_lost` right at the wake edge.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_PROG  = 2'd1,
    OP_SLEEP = 2'd2,
    OP_WAKE  = 2'd3
  } cmd_op_t;

  typedef enum logic [2:0] {
    S_PWRUP,
    S_IDLE,
    S_DRAIN_CFG,
    S_CFG_SETUP,
    S_CFG_WRITE,
    S_DRAIN_SLP,
    S_SLEEP,
    S_RECOVER
  } seq_state_t;

  function automatic logic zz_low_state(input seq_state_t s);
    return (s == S_CFG_SETUP) || (s == S_CFG_WRITE) || (s == S_SLEEP);
  endfunction

endpackage

// File: rtl/psram_pwr_timer.sv
module psram_pwr_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/psram_pwr_cfg_shadow.sv
module psram_pwr_cfg_shadow #(
  parameter int              CFG_W       = 5,
  parameter logic [CFG_W-1:0] CFG_RST    = 5'b10000,
  parameter int              DEEP_EN_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             set_lost,
  output logic [CFG_W-1:0] cfg,
  output logic             deep_sel,
  output logic             mem_lost
);

  logic [CFG_W-1:0] cfg_q;
  logic             lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      lost_q <= 1'b0;
    end else begin
      if (wr_en)    cfg_q  <= wr_data;
      if (set_lost) lost_q <= 1'b1;
    end
  end

  assign cfg      = cfg_q;
  assign deep_sel = ~cfg_q[DEEP_EN_BIT];
  assign mem_lost = lost_q;

endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
  import psram_pwr_pkg::*;
#(
  parameter int CFG_W         = 5,
  parameter int CNT_W         = 16,
  parameter int CFG_SETUP_CYC = 200,
  parameter int MIN_SLEEP_CYC = 1600,
  parameter int RECOVER_CYC   = 40000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [CFG_W-1:0] cmd_cfg,
  input  logic             acc_idle,
  input  logic             cfg_wr_done,
  input  logic             tmr_expired,
  input  logic             deep_sel,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             shadow_wr,
  output logic             set_lost,
  output logic [CFG_W-1:0] code,
  output logic             cfg_wr_req,
  output logic             zz_n,
  output logic             acc_grant,
  output logic             st_sleep,
  output logic             st_recover
);

  seq_state_t       state_q, state_n;
  cmd_op_t          op;
  logic             accept;
  logic             wake_req;
  logic             wake_pend_q, wake_pend_n;
  logic [CFG_W-1:0] code_q;
  logic             zz_n_q, grant_q, req_q, sleep_q, rec_q;

  assign op        = cmd_op_t'(cmd_op);
  assign cmd_ready = (state_q == S_IDLE) || ((state_q == S_SLEEP) && !wake_pend_q);
  assign accept    = cmd_valid && cmd_ready;
  assign wake_req  = wake_pend_q || (accept && (op == OP_WAKE));

  always_comb begin
    state_n   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    shadow_wr = 1'b0;
    set_lost  = 1'b0;
    case (state_q)
      S_PWRUP: begin
        if (tmr_expired) state_n = S_IDLE;
      end
      S_IDLE: begin
        if (accept && (op == OP_PROG))  state_n = S_DRAIN_CFG;
        if (accept && (op == OP_SLEEP)) state_n = S_DRAIN_SLP;
      end
      S_DRAIN_CFG: begin
        if (acc_idle) begin
          state_n  = S_CFG_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(CFG_SETUP_CYC);
        end
      end
      S_CFG_SETUP: begin
        if (tmr_expired) state_n = S_CFG_WRITE;
      end
      S_CFG_WRITE: begin
        if (cfg_wr_done) begin
          state_n   = S_IDLE;
          shadow_wr = 1'b1;
        end
      end
      S_DRAIN_SLP: begin
        if (acc_idle) begin
          state_n  = S_SLEEP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(MIN_SLEEP_CYC);
        end
      end
      S_SLEEP: begin
        if (tmr_expired && wake_req) begin
          if (deep_sel) begin
            state_n  = S_RECOVER;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RECOVER_CYC);
            set_lost = 1'b1;
          end else begin
            state_n = S_IDLE;
          end
        end
      end
      S_RECOVER: begin
        if (tmr_expired) state_n = S_IDLE;
      end
      default: state_n = S_PWRUP;
    endcase
  end

  assign wake_pend_n = (state_q == S_SLEEP) && (state_n == S_SLEEP) && wake_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_PWRUP;
      wake_pend_q <= 1'b0;
      code_q      <= '0;
      zz_n_q      <= 1'b1;
      grant_q     <= 1'b0;
      req_q       <= 1'b0;
      sleep_q     <= 1'b0;
      rec_q       <= 1'b0;
    end else begin
      state_q     <= state_n;
      wake_pend_q <= wake_pend_n;
      if (accept && (op == OP_PROG) && (state_q == S_IDLE)) code_q <= cmd_cfg;
      zz_n_q  <= !zz_low_state(state_n);
      grant_q <= (state_n == S_IDLE);
      req_q   <= (state_n == S_CFG_WRITE);
      sleep_q <= (state_n == S_SLEEP);
      rec_q   <= (state_n == S_RECOVER);
    end
  end

  assign code       = code_q;
  assign cfg_wr_req = req_q;
  assign zz_n       = zz_n_q;
  assign acc_grant  = grant_q;
  assign st_sleep   = sleep_q;
  assign st_recover = rec_q;

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
  parameter int               CFG_W         = 5,
  parameter logic [CFG_W-1:0] CFG_RST       = 5'b10000,
  parameter int               DEEP_EN_BIT   = 4,
  parameter int               PWRUP_CYC     = 40000,
  parameter int               CFG_SETUP_CYC = 200,
  parameter int               MIN_SLEEP_CYC = 1600,
  parameter int               RECOVER_CYC   = 40000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [CFG_W-1:0] cmd_cfg,
  input  logic             acc_idle,
  output logic             cfg_wr_req,
  output logic [CFG_W-1:0] cfg_wr_addr,
  input  logic             cfg_wr_done,
  output logic             zz_n,
  output logic             acc_grant,
  output logic             st_sleep,
  output logic             st_recover,
  output logic             st_mem_lost,
  output logic [CFG_W-1:0] st_cfg
);

  localparam int MAX_A   = (PWRUP_CYC > RECOVER_CYC) ? PWRUP_CYC : RECOVER_CYC;
  localparam int MAX_B   = (CFG_SETUP_CYC > MIN_SLEEP_CYC) ? CFG_SETUP_CYC : MIN_SLEEP_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic             shadow_wr, set_lost, deep_sel;
  logic [CFG_W-1:0] code;

  psram_pwr_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(PWRUP_CYC)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  psram_pwr_cfg_shadow #(
    .CFG_W      (CFG_W),
    .CFG_RST    (CFG_RST),
    .DEEP_EN_BIT(DEEP_EN_BIT)
  ) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (shadow_wr),
    .wr_data (code),
    .set_lost(set_lost),
    .cfg     (st_cfg),
    .deep_sel(deep_sel),
    .mem_lost(st_mem_lost)
  );

  psram_pwr_fsm #(
    .CFG_W        (CFG_W),
    .CNT_W        (CNT_W),
    .CFG_SETUP_CYC(CFG_SETUP_CYC),
    .MIN_SLEEP_CYC(MIN_SLEEP_CYC),
    .RECOVER_CYC  (RECOVER_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_cfg    (cmd_cfg),
    .acc_idle   (acc_idle),
    .cfg_wr_done(cfg_wr_done),
    .tmr_expired(tmr_expired),
    .deep_sel   (deep_sel),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .shadow_wr  (shadow_wr),
    .set_lost   (set_lost),
    .code       (code),
    .cfg_wr_req (cfg_wr_req),
    .zz_n       (zz_n),
    .acc_grant  (acc_grant),
    .st_sleep   (st_sleep),
    .st_recover (st_recover)
  );

  assign cfg_wr_addr = code;

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int CFG_W         = 5,
  parameter int CFG_SETUP_CYC = 200,
  parameter int MIN_SLEEP_CYC = 1600,
  parameter int RECOVER_CYC   = 40000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             acc_idle,
  input logic             cfg_wr_req,
  input logic [CFG_W-1:0] cfg_wr_addr,
  input logic             zz_n,
  input logic             acc_grant,
  input logic             st_sleep,
  input logic             st_recover,
  input logic             st_mem_lost
);

  logic [31:0] zl_cnt, rec_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zl_cnt  <= '0;
      rec_cnt <= '0;
    end else begin
      zl_cnt  <= zz_n ? 32'd0 : zl_cnt + 32'd1;
      rec_cnt <= st_recover ? rec_cnt + 32'd1 : 32'd0;
    end
  end

  assert_grant_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant |-> (zz_n && !cfg_wr_req));

  assert_ready_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !st_sleep) |-> acc_grant);

  assert_drain_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zz_n) |-> $past(acc_idle));

  assert_req_zz_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_req |-> !zz_n);

  assert_setup_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_wr_req) |-> (zl_cnt >= 32'(CFG_SETUP_CYC)));

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_req && $past(cfg_wr_req)) |-> (cfg_wr_addr == $past(cfg_wr_addr)));

  assert_min_dwell_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_sleep) |-> (zl_cnt >= 32'(MIN_SLEEP_CYC)));

  assert_recover_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_recover) |-> (rec_cnt >= 32'(RECOVER_CYC)));

  assert_lost_on_deep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_mem_lost) |-> st_recover);

  assert_lost_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_mem_lost |=> st_mem_lost);

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .CFG_W        (CFG_W),
  .CFG_SETUP_CYC(CFG_SETUP_CYC),
  .MIN_SLEEP_CYC(MIN_SLEEP_CYC),
  .RECOVER_CYC  (RECOVER_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .acc_idle   (acc_idle),
  .cfg_wr_req (cfg_wr_req),
  .cfg_wr_addr(cfg_wr_addr),
  .zz_n       (zz_n),
  .acc_grant  (acc_grant),
  .st_sleep   (st_sleep),
  .st_recover (st_recover),
  .st_mem_lost(st_mem_lost)
);

// File: tb/test_psram_pwr_seq.sv
module test_psram_pwr_seq;

  localparam int CFG_W   = 5;
  localparam int PWRUP   = 60;
  localparam int SETUP   = 6;
  localparam int MINSLP  = 12;
  localparam int REC     = 40;
  localparam int DEEPBIT = 4;

  localparam logic [7:0] VEC [0:7] = '{
    8'h52, 8'h80, 8'h81, 8'h43, 8'h80, 8'h81, 8'h4D, 8'h82
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [CFG_W-1:0] cmd_cfg = '0;
  logic acc_idle = 1'b1;
  logic cfg_wr_req;
  logic [CFG_W-1:0] cfg_wr_addr;
  logic cfg_wr_done = 1'b0;
  logic zz_n, acc_grant, st_sleep, st_recover, st_mem_lost;
  logic [CFG_W-1:0] st_cfg;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [CFG_W-1:0] cur_cfg = 5'b10000;
  logic exp_lost = 1'b0;

  logic mon_clr = 1'b0;
  int zl = 0, last_zl = 0, rl = 0, last_rl = 0;
  logic zz_prev = 1'b1;
  logic gaw = 1'b0;

  always #2.5 clk = ~clk;

  psram_pwr_seq #(
    .PWRUP_CYC(PWRUP), .CFG_SETUP_CYC(SETUP),
    .MIN_SLEEP_CYC(MINSLP), .RECOVER_CYC(REC)
  ) i_psram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_cfg(cmd_cfg), .acc_idle(acc_idle),
    .cfg_wr_req(cfg_wr_req), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_done(cfg_wr_done),
    .zz_n(zz_n), .acc_grant(acc_grant), .st_sleep(st_sleep),
    .st_recover(st_recover), .st_mem_lost(st_mem_lost), .st_cfg(st_cfg)
  );

  always @(negedge clk) begin
    if (mon_clr) begin
      zl = 0; last_zl = 0; rl = 0; last_rl = 0; gaw = 1'b0;
    end else begin
      if (!zz_n) zl++;
      else if (zl != 0) begin last_zl = zl; zl = 0; end
      if (st_recover) rl++;
      else if (rl != 0) begin last_rl = rl; rl = 0; end
      if (zz_n && !zz_prev) gaw = acc_grant;
    end
    zz_prev = zz_n;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [CFG_W-1:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_cfg = c;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1;
    repeat (2) @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic wait_grant(input string tag);
    int n = 0;
    while (!acc_grant && n < 500) begin @(negedge clk); n++; end
    chk(acc_grant == 1'b1, tag, acc_grant, 1);
    @(negedge clk);
  endtask

  task automatic do_prog(input logic [CFG_W-1:0] c);
    int zlow = 0;
    int n = 0;
    send(2'd1, c);
    while (!cfg_wr_req && n < 500) begin
      if (!zz_n) zlow++;
      if (acc_grant) chk(1'b0, "R10 grant during program", 1, 0);
      @(negedge clk); n++;
    end
    chk(zlow >= SETUP, "R5 setup before write", zlow, SETUP);
    chk(cfg_wr_addr == c, "R5 write address", cfg_wr_addr, c);
    repeat (3) @(negedge clk);
    chk(cfg_wr_req && !zz_n && cfg_wr_addr == c, "R5 request held", cfg_wr_req, 1);
    cfg_wr_done = 1'b1;
    @(negedge clk);
    cfg_wr_done = 1'b0;
    wait_grant("R5 grant after program");
    cur_cfg = c;
    chk(zz_n == 1'b1, "R5 zz released", zz_n, 1);
    chk(st_cfg == c, "R5 config stored", st_cfg, c);
  endtask

  task automatic do_sleep(input int mode);
    bit deep;
    deep = (cur_cfg[DEEPBIT] == 1'b0);
    clear_mon();
    if (mode == 2) acc_idle = 1'b0;
    send(2'd2, '0);
    chk(acc_grant == 1'b0, "R4 grant withdrawn", acc_grant, 0);
    if (mode == 1) begin
      send(2'd3, '0);
      chk(cmd_ready == 1'b0, "R3 ready low with wake pending", cmd_ready, 0);
      chk(zz_n == 1'b0, "R7 early wake held", zz_n, 0);
    end else begin
      if (mode == 2) begin
        repeat (10) @(negedge clk);
        chk(zz_n == 1'b1 && !st_sleep, "R4 waits for idle bus", zz_n, 1);
        acc_idle = 1'b1;
        @(negedge clk);
        chk(zz_n == 1'b0, "R4 zz falls after idle", zz_n, 0);
      end
      if (mode == 3) begin
        send(2'd1, 5'b01010);
        send(2'd2, '0);
        repeat (2) @(negedge clk);
        chk(!cfg_wr_req && st_cfg == cur_cfg && !zz_n, "R11 ignored in sleep", st_cfg, cur_cfg);
      end
      repeat (MINSLP + 4) @(negedge clk);
      chk(st_sleep && !acc_grant && !zz_n, "R6 still asleep", st_sleep, 1);
      send(2'd3, '0);
    end
    wait_grant("R6 grant after wake");
    chk(last_zl >= MINSLP, mode == 1 ? "R7 dwell met" : "R6 dwell met", last_zl, MINSLP);
    if (deep) begin
      chk(last_rl >= REC, "R8 recovery length", last_rl, REC);
      exp_lost = 1'b1;
    end else begin
      chk(last_rl == 0 && gaw, "R8 no recovery in standby", last_rl, 0);
    end
    chk(st_mem_lost == exp_lost, "R9 contents-lost flag", st_mem_lost, exp_lost);
  endtask

  initial begin
    int pc;
    bit early;
    repeat (3) @(negedge clk);
    chk(zz_n && !acc_grant && !cmd_ready && !cfg_wr_req, "R1 reset outputs", zz_n, 1);
    chk(st_cfg == 5'b10000 && !st_mem_lost && !st_sleep && !st_recover,
        "R1 reset status", st_cfg, 5'b10000);
    rst_n = 1'b1;
    pc = 0; early = 1'b0;
    while (!acc_grant && pc < 1000) begin
      if (cmd_ready) early = 1'b1;
      @(negedge clk); pc++;
    end
    chk(pc >= PWRUP && pc <= PWRUP + 2, "R2 power-up wait", pc, PWRUP);
    chk(!early, "R2 ready held during power-up", early, 0);

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][7:6] == 2'd1) do_prog(VEC[i][4:0]);
      else do_sleep(int'(VEC[i][1:0]));
    end

    send(2'd3, '0);
    send(2'd0, '0);
    repeat (3) @(negedge clk);
    chk(zz_n && acc_grant && cmd_ready && st_cfg == cur_cfg && !st_sleep,
        "R11 wake/no-op in idle", acc_grant, 1);
    do_sleep(3);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!st_mem_lost && st_cfg == 5'b10000, "R9 flag cleared only by reset", st_mem_lost, 0);
    summary();
  end

endmodule